// File: doc/BRIEF.md
# Byte ALU with Destination Select

This block carries out single-operand byte operations on an 8-bit working register and a bank of 128 byte-wide file registers. Each cycle the sequencer presents a decoded operation code, a 7-bit file address, a 3-bit bit index and a one-bit destination select. On the next rising clock edge the block commits the result either into the working register or back into the addressed file register, and it updates the zero flag according to that operation's own rule.

The addressed file register is always visible on a read port, and the bit picked by the bit index is brought out on its own pin. The sequencer uses that pin to decide whether to skip the following instruction. Instruction decode, banking, indirect addressing and special-register side effects sit outside this block.

Top module: `byte_alu_core`

## Requirements
- R1: After reset the working register reads 00h, the zero flag reads 0 and every file register reads 00h.
- R2: Operation code 0 (clear file) writes 00h to the addressed file register and sets the zero flag to 1. The working register keeps its value.
- R3: Operation code 1 (clear working) writes 00h to the working register and sets the zero flag to 1. No file register changes.
- R4: Operation code 2 (complement) produces the bitwise inverse of the addressed file register.
- R5: Operation code 3 (decrement) produces the addressed file register minus one. 00h wraps to FFh, and no flag other than zero is touched.
- R6: For codes 2 and 3, a destination select of 0 writes the result to the working register and leaves the file register unchanged. A select of 1 writes the result to the file register and leaves the working register unchanged.
- R7: For codes 2 and 3 the zero flag becomes 1 when the 8-bit result is 00h and 0 otherwise.
- R8: Operation code 4 (bit test) writes no register and leaves the zero flag unchanged. The bit output always equals bit `bit_sel` of the addressed file register.
- R9: When `op_valid` is low, or the operation code is 5, 6 or 7, no register and no flag changes.
- R10: A write commits on the single rising edge that ends the operation's cycle. Before that edge the read port returns the old value of the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Decoded operation (0 clear file, 1 clear working, 2 complement, 3 decrement, 4 bit test) |
| f_addr | input | 7 | File register address |
| bit_sel | input | 3 | Bit index for the bit output |
| dest_f | input | 1 | Destination select: 0 working register, 1 file register |
| w_q | output | 8 | Working register |
| z_q | output | 1 | Zero flag |
| f_rdata | output | 8 | Current contents of the addressed file register |
| bit_q | output | 1 | Selected bit of the addressed file register |

## Verification
A wrong destination decode or a corrupted file entry shows up one cycle after the faulty operation. It appears on `w_q`, or on `f_rdata` while the same address is still presented. Because complement and decrement with destination 0 copy a transformed file value into `w_q`, a stale entry also surfaces the next time any operation reads that address. A wrong zero rule is visible on `z_q` right after the edge. An erroneous write during a bit test or an idle cycle is caught at the next read of the disturbed register or flag.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  localparam int BIT_W  = 3;
  localparam int OP_W   = 3;

  localparam logic [OP_W-1:0] OP_CLRF = 3'd0;
  localparam logic [OP_W-1:0] OP_CLRW = 3'd1;
  localparam logic [OP_W-1:0] OP_COMF = 3'd2;
  localparam logic [OP_W-1:0] OP_DECF = 3'd3;
  localparam logic [OP_W-1:0] OP_BTST = 3'd4;

  function automatic logic [DATA_W-1:0] alu_inv(input logic [DATA_W-1:0] a);
    return ~a;
  endfunction

  function automatic logic [DATA_W-1:0] alu_dec(input logic [DATA_W-1:0] a);
    return a - {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic alu_is_zero(input logic [DATA_W-1:0] a);
    return (a == '0);
  endfunction
endpackage

// File: rtl/byte_alu_regfile.sv
module byte_alu_regfile
  import byte_alu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R10: a write to the address being read appears after exactly one edge
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == raddr) |=> (raddr != $past(raddr)) || (rdata == $past(wdata)));
endmodule

// File: rtl/byte_alu_exec.sv
module byte_alu_exec
  import byte_alu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = OP_W
) (
  input  logic          op_valid,
  input  logic [OW-1:0] op_code,
  input  logic          dest_f,
  input  logic [DW-1:0] f_val,
  output logic [DW-1:0] result,
  output logic          w_we,
  output logic          f_we,
  output logic          z_we,
  output logic          z_next
);
  always_comb begin
    result = '0;
    w_we   = 1'b0;
    f_we   = 1'b0;
    z_we   = 1'b0;
    z_next = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_CLRF: begin
          f_we   = 1'b1;
          z_we   = 1'b1;
          z_next = 1'b1;
        end
        OP_CLRW: begin
          w_we   = 1'b1;
          z_we   = 1'b1;
          z_next = 1'b1;
        end
        OP_COMF: begin
          result = alu_inv(f_val);
          w_we   = !dest_f;
          f_we   = dest_f;
          z_we   = 1'b1;
          z_next = alu_is_zero(result);
        end
        OP_DECF: begin
          result = alu_dec(f_val);
          w_we   = !dest_f;
          f_we   = dest_f;
          z_we   = 1'b1;
          z_next = alu_is_zero(result);
        end
        default: ;
      endcase
    end
  end

  // R6: one destination at most per operation
  p_one_dest_r6: assert final (!(w_we && f_we));
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
  import byte_alu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int BW = BIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [AW-1:0] f_addr,
  input  logic [BW-1:0] bit_sel,
  input  logic          dest_f,
  output logic [DW-1:0] w_q,
  output logic          z_q,
  output logic [DW-1:0] f_rdata,
  output logic          bit_q
);
  logic [DW-1:0] exec_result;
  logic          ev_w_write;
  logic          ev_f_write;
  logic          ev_z_write;
  logic          ev_z_value;
  logic [DW-1:0] w_r;
  logic          z_r;

  byte_alu_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ev_f_write),
    .waddr (f_addr),
    .wdata (exec_result),
    .raddr (f_addr),
    .rdata (f_rdata)
  );

  byte_alu_exec #(.DW(DW), .OW(3)) u_exec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .dest_f   (dest_f),
    .f_val    (f_rdata),
    .result   (exec_result),
    .w_we     (ev_w_write),
    .f_we     (ev_f_write),
    .z_we     (ev_z_write),
    .z_next   (ev_z_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_r <= '0;
      z_r <= 1'b0;
    end else begin
      if (ev_w_write) w_r <= exec_result;
      if (ev_z_write) z_r <= ev_z_value;
    end
  end

  assign w_q   = w_r;
  assign z_q   = z_r;
  assign bit_q = f_rdata[bit_sel];

  p_clrf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLRF) |=> z_q && $stable(w_q));
  p_clrw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLRW) |=> (w_q == '0) && z_q);
  p_comf_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_COMF && !dest_f) |=> w_q == ~$past(f_rdata));
  p_decf_w_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_DECF && !dest_f) |=> w_q == $past(f_rdata) - 8'd1);
  p_dest_file_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dest_f && (op_code == OP_COMF || op_code == OP_DECF)) |=> $stable(w_q));
  p_btst_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_BTST) |=> $stable(w_q) && $stable(z_q));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code > OP_BTST) |=> $stable(w_q) && $stable(z_q));
endmodule

// File: tb/byte_alu_core_bench.sv
module byte_alu_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [6:0] f_addr = 7'd0;
  logic [2:0] bit_sel = 3'd0;
  logic       dest_f = 1'b0;
  logic [7:0] w_q;
  logic       z_q;
  logic [7:0] f_rdata;
  logic       bit_q;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_file [128];
  logic [7:0] m_w;
  logic       m_z;

  always #2 clk = ~clk;

  byte_alu_core u_byte_alu_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .f_addr(f_addr), .bit_sel(bit_sel), .dest_f(dest_f),
    .w_q(w_q), .z_q(z_q), .f_rdata(f_rdata), .bit_q(bit_q)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // tags: R2 clear file, R3 clear working, R4 complement, R5 decrement,
  // R8 bit test, R9 no operation
  function automatic string tag_of(input logic v, input logic [2:0] op);
    if (!v) return "R9";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic do_op(input logic v, input logic [2:0] op, input logic [6:0] a,
                       input logic [2:0] b, input logic d);
    logic [7:0] old_f;
    logic [7:0] res;
    string t;
    @(negedge clk);
    op_valid = v; op_code = op; f_addr = a; bit_sel = b; dest_f = d;
    #1;
    old_f = m_file[a];
    chk("R10", f_rdata, old_f);
    chk("R8", {7'd0, bit_q}, {7'd0, old_f[b]});
    t = tag_of(v, op);
    if (v) begin
      case (op)
        3'd0: begin m_file[a] = 8'h00; m_z = 1'b1; end
        3'd1: begin m_w = 8'h00; m_z = 1'b1; end
        3'd2, 3'd3: begin
          res = (op == 3'd2) ? (8'hFF ^ old_f) : (old_f + 8'hFF);
          if (d) m_file[a] = res; else m_w = res;
          m_z = (res == 8'h00);
        end
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    chk(t, w_q, m_w);
    chk((v && (op == 3'd2 || op == 3'd3)) ? "R7" : t, {7'd0, z_q}, {7'd0, m_z});
    chk((v && (op == 3'd2 || op == 3'd3)) ? "R6" : t, f_rdata, m_file[a]);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 128; i++) m_file[i] = 8'h00;
    m_w = 8'h00; m_z = 1'b0;
    #9 rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1", w_q, 8'h00);
    chk("R1", {7'd0, z_q}, 8'h00);
    for (int i = 0; i < 128; i++) begin
      f_addr = i[6:0];
      #0.1;
      chk("R1", f_rdata, 8'h00);
    end
    // directed corners: R5 wrap, R4, R7 zero, R6 destination, R3, R2, R9
    do_op(1'b1, 3'd3, 7'd5, 3'd7, 1'b1);   // 00 -> FF in file
    do_op(1'b1, 3'd3, 7'd5, 3'd0, 1'b0);   // W = FE, Z = 0
    do_op(1'b1, 3'd2, 7'd7, 3'd2, 1'b0);   // W = FF
    do_op(1'b1, 3'd2, 7'd5, 3'd1, 1'b1);   // FF -> 00, Z = 1
    do_op(1'b1, 3'd2, 7'd9, 3'd0, 1'b1);   // 00 -> FF
    do_op(1'b1, 3'd3, 7'd9, 3'd0, 1'b1);   // FF -> FE
    do_op(1'b1, 3'd2, 7'd9, 3'd0, 1'b1);   // FE -> 01
    do_op(1'b1, 3'd3, 7'd9, 3'd0, 1'b0);   // W = 00, Z = 1
    do_op(1'b1, 3'd4, 7'd9, 3'd0, 1'b1);   // bit test, no change
    do_op(1'b1, 3'd1, 7'd9, 3'd0, 1'b1);   // clear W
    do_op(1'b1, 3'd0, 7'd9, 3'd0, 1'b0);   // clear file
    do_op(1'b0, 3'd2, 7'd5, 3'd0, 1'b1);   // not valid
    do_op(1'b1, 3'd6, 7'd5, 3'd0, 1'b1);   // unused code
    for (int n = 0; n < 3000; n++) begin
      do_op(($urandom % 8) != 0, 3'($urandom_range(0, 7)),
            7'($urandom_range(0, 15)), 3'($urandom_range(0, 7)), 1'($urandom % 2));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule